// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out the next program counter for a small 8-bit controller core whose program space is 16 bits wide. Each cycle the core hands it the address of the byte that follows the current instruction, a jump-kind code and the operand fields the decoder pulled out of the instruction. The block returns the destination address and a flag saying whether control actually leaves the sequential path. Branch conditions are evaluated elsewhere and arrive as a single "condition true" bit.

Four ways of forming a destination are supported: a full 16-bit address, an 11-bit field spliced into the 2 KB page of the following instruction, a signed 8-bit displacement added to the following instruction's address, and an indexed jump that adds the unsigned accumulator to the data pointer. A separate output gives the code-read address used by table lookups, formed from the accumulator plus either the data pointer or the next-instruction address. Every sum wraps modulo 2^16. Results are registered, so they appear one clock after the request is accepted.

Top module: `bta_target_gen`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid`, `taken`, `target` and `rd_addr` to zero at the clock edge where it is sampled high.
- R2: A request is accepted at a rising edge where `in_valid` is high and its results appear on the outputs with `out_valid` high after that same edge; after an edge where `in_valid` is low, `out_valid` is low and `target`, `taken` and `rd_addr` keep their previous values.
- R3: `kind` is a 3-bit code: 0 sequential, 1 long absolute, 2 in-page absolute, 3 relative, 4 conditional relative, 5 indexed jump; codes 6 and 7 behave exactly like code 0.
- R4: Long absolute: `target` equals `long_addr` and `taken` is 1, whatever the value of `cond_true`.
- R5: In-page absolute: `target[15:11]` equals `next_pc[15:11]`, `target[10:0]` equals `page_addr`, and `taken` is 1.
- R6: Relative: `target` equals `next_pc` plus `rel_ofs` read as a signed two's-complement value (-128..+127), modulo 2^16, and `taken` is 1.
- R7: Conditional relative: with `cond_true` high the result is as in R6; with it low `target` equals `next_pc` and `taken` is 0.
- R8: Indexed jump: `target` equals the zero-extended `acc` plus `dptr` modulo 2^16 and `taken` is 1; `idx_use_pc` has no effect on `target`.
- R9: For every accepted request, regardless of `kind`, `rd_addr` equals zero-extended `acc` plus `next_pc` when `idx_use_pc` is 1, or plus `dptr` when it is 0, modulo 2^16.
- R10: Sequential and reserved codes give `target` equal to `next_pc` and `taken` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| kind | input | 3 | Jump-kind code (see R3) |
| next_pc | input | 16 | Address of the first byte of the following instruction |
| long_addr | input | 16 | Full destination operand |
| page_addr | input | 11 | In-page destination operand |
| rel_ofs | input | 8 | Signed displacement operand |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| idx_use_pc | input | 1 | Code-read base select: 1 next_pc, 0 dptr |
| cond_true | input | 1 | Branch condition result |
| out_valid | output | 1 | Registered results are fresh |
| target | output | 16 | Next program counter |
| taken | output | 1 | Control leaves the sequential path |
| rd_addr | output | 16 | Indexed code-read address |

## Verification
The bench builds the block with its default widths: a 16-bit address, an 11-bit page field, an 8-bit displacement and an 8-bit accumulator. With these values the 2 KB page edges (such as 0x0FFF/0x1000), the full-range wrap at 0xFFFF and both displacement extremes are all reachable with short directed vectors. A random sweep then compares every kind against an arithmetic model written in the bench, with addresses drawn across the whole 64 KB range so wrap-around occurs often.

// File: rtl/bta_pkg.sv
package bta_pkg;

  typedef enum logic [2:0] {
    JK_SEQ  = 3'd0,
    JK_LONG = 3'd1,
    JK_PAGE = 3'd2,
    JK_REL  = 3'd3,
    JK_RELC = 3'd4,
    JK_IDX  = 3'd5,
    JK_RSV6 = 3'd6,
    JK_RSV7 = 3'd7
  } jump_kind_e;

endpackage

// File: rtl/bta_page_splice.sv
// Keeps the page bits of base and replaces the in-page bits with field.
module bta_page_splice #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 11
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [PAGE_W-1:0] field,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - PAGE_W;
  localparam logic [ADDR_W-1:0] HI_MASK = {{HI_W{1'b1}}, {PAGE_W{1'b0}}};

  logic [ADDR_W-1:0] field_ext;

  always_comb begin
    field_ext = {{HI_W{1'b0}}, field};
    addr      = (base & HI_MASK) | field_ext;
  end
endmodule

// File: rtl/bta_rel_add.sv
// Adds a signed displacement to a base address, wrapping at 2^ADDR_W.
module bta_rel_add #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] ofs_ext;

  generate
    if (OFS_W < ADDR_W) begin : g_sext
      assign ofs_ext = {{(ADDR_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    end else begin : g_full
      assign ofs_ext = ofs[ADDR_W-1:0];
    end
  endgenerate

  assign addr = base + ofs_ext;
endmodule

// File: rtl/bta_idx_add.sv
// Adds an unsigned index to a base address, wrapping at 2^ADDR_W.
module bta_idx_add #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] idx_ext;

  generate
    if (IDX_W < ADDR_W) begin : g_zext
      assign idx_ext = {{(ADDR_W-IDX_W){1'b0}}, idx};
    end else begin : g_full
      assign idx_ext = idx[ADDR_W-1:0];
    end
  endgenerate

  assign addr = base + idx_ext;
endmodule

// File: rtl/bta_target_gen.sv
module bta_target_gen
  import bta_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 11,
  parameter int OFS_W  = 8,
  parameter int ACC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        kind,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [ADDR_W-1:0] long_addr,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [OFS_W-1:0]  rel_ofs,
  input  logic [ACC_W-1:0]  acc,
  input  logic [ADDR_W-1:0] dptr,
  input  logic              idx_use_pc,
  input  logic              cond_true,
  output logic              out_valid,
  output logic [ADDR_W-1:0] target,
  output logic              taken,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int HI_W = ADDR_W - PAGE_W;

  jump_kind_e        kind_e;
  logic [ADDR_W-1:0] page_tgt;
  logic [ADDR_W-1:0] rel_tgt;
  logic [ADDR_W-1:0] jmp_idx_tgt;
  logic [ADDR_W-1:0] rd_base;
  logic [ADDR_W-1:0] rd_nxt;
  logic [ADDR_W-1:0] tgt_nxt;
  logic              taken_nxt;

  assign kind_e  = jump_kind_e'(kind);
  assign rd_base = idx_use_pc ? next_pc : dptr;

  bta_page_splice #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_page (
    .base (next_pc),
    .field(page_addr),
    .addr (page_tgt)
  );

  bta_rel_add #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_rel (
    .base(next_pc),
    .ofs (rel_ofs),
    .addr(rel_tgt)
  );

  bta_idx_add #(.ADDR_W(ADDR_W), .IDX_W(ACC_W)) u_jmp_idx (
    .base(dptr),
    .idx (acc),
    .addr(jmp_idx_tgt)
  );

  bta_idx_add #(.ADDR_W(ADDR_W), .IDX_W(ACC_W)) u_rd_idx (
    .base(rd_base),
    .idx (acc),
    .addr(rd_nxt)
  );

  always_comb begin
    tgt_nxt   = next_pc;
    taken_nxt = 1'b0;
    case (kind_e)
      JK_LONG: begin tgt_nxt = long_addr;   taken_nxt = 1'b1; end
      JK_PAGE: begin tgt_nxt = page_tgt;    taken_nxt = 1'b1; end
      JK_REL:  begin tgt_nxt = rel_tgt;     taken_nxt = 1'b1; end
      JK_RELC: begin
        if (cond_true) begin
          tgt_nxt   = rel_tgt;
          taken_nxt = 1'b1;
        end
      end
      JK_IDX:  begin tgt_nxt = jmp_idx_tgt; taken_nxt = 1'b1; end
      default: begin tgt_nxt = next_pc;     taken_nxt = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      target    <= '0;
      taken     <= 1'b0;
      rd_addr   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        target  <= tgt_nxt;
        taken   <= taken_nxt;
        rd_addr <= rd_nxt;
      end
    end
  end

  // R1: outputs are clear in the first cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !taken && target == '0 && rd_addr == '0));

  // R2: out_valid tracks the accept strobe of the previous edge
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R2: idle cycles leave results untouched
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(target) && $stable(taken) && $stable(rd_addr)));

  // R4: long absolute target copies the operand
  a_r4_long_target: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(kind) == 3'd1)
      |-> (taken && target == $past(long_addr)));

  // R5: in-page target keeps the page bits of the following instruction
  a_r5_page_keep: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(kind) == 3'd2)
      |-> (taken && target[ADDR_W-1:PAGE_W] == $past(next_pc[ADDR_W-1:PAGE_W])
           && target[PAGE_W-1:0] == $past(page_addr)));

  // R7: a false condition falls through without taking
  a_r7_false_falls: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(kind) == 3'd4 && !$past(cond_true))
      |-> (!taken && target == $past(next_pc)));

  // R10: sequential and reserved codes never take
  a_r10_seq_not_taken: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && ($past(kind) == 3'd0 || $past(kind) >= 3'd6))
      |-> (!taken && target == $past(next_pc)));

  // Elaboration-time sanity on the page split
  initial begin
    a_page_fits: assert (HI_W > 0 && OFS_W <= ADDR_W && ACC_W <= ADDR_W);
  end
endmodule

// File: tb/bta_target_gen_bench.sv
module bta_target_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  localparam int NRAND = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic [15:0] next_pc = '0;
  logic [15:0] long_addr = '0;
  logic [10:0] page_addr = '0;
  logic [7:0]  rel_ofs = '0;
  logic [7:0]  acc = '0;
  logic [15:0] dptr = '0;
  logic        idx_use_pc = 1'b0;
  logic        cond_true = 1'b0;
  logic        out_valid;
  logic [15:0] target;
  logic        taken;
  logic [15:0] rd_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bta_target_gen u_bta_target_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind),
    .next_pc(next_pc), .long_addr(long_addr), .page_addr(page_addr),
    .rel_ofs(rel_ofs), .acc(acc), .dptr(dptr), .idx_use_pc(idx_use_pc),
    .cond_true(cond_true), .out_valid(out_valid), .target(target),
    .taken(taken), .rd_addr(rd_addr)
  );

  // kind,next,long,page,ofs,acc,dptr,usepc,cond | exp target, exp taken, exp rd
  localparam logic [112:0] VEC [NVEC] = '{
    {3'd1, 16'h1234, 16'hBEEF, 11'h000, 8'h00, 8'h10, 16'h2000, 1'b0, 1'b0, 16'hBEEF, 1'b1, 16'h2010},
    {3'd2, 16'h0FFE, 16'h0000, 11'h7FF, 8'h00, 8'hFF, 16'h0000, 1'b1, 1'b0, 16'h0FFF, 1'b1, 16'h10FD},
    {3'd2, 16'hF801, 16'h0000, 11'h003, 8'h00, 8'h00, 16'hFFFF, 1'b0, 1'b0, 16'hF803, 1'b1, 16'hFFFF},
    {3'd3, 16'h1000, 16'h0000, 11'h000, 8'h80, 8'h01, 16'hFFFF, 1'b0, 1'b0, 16'h0F80, 1'b1, 16'h0000},
    {3'd3, 16'hFFF0, 16'h0000, 11'h000, 8'h7F, 8'h20, 16'h0000, 1'b1, 1'b0, 16'h006F, 1'b1, 16'h0010},
    {3'd4, 16'h0005, 16'h0000, 11'h000, 8'hF0, 8'h00, 16'h1234, 1'b0, 1'b1, 16'hFFF5, 1'b1, 16'h1234},
    {3'd4, 16'h4321, 16'h0000, 11'h000, 8'h10, 8'h80, 16'h0080, 1'b0, 1'b0, 16'h4321, 1'b0, 16'h0100},
    {3'd5, 16'h0100, 16'h0000, 11'h000, 8'h00, 8'hFF, 16'hFF01, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h01FF},
    {3'd0, 16'hABCD, 16'h7777, 11'h123, 8'h05, 8'h33, 16'h0000, 1'b0, 1'b1, 16'hABCD, 1'b0, 16'h0033},
    {3'd7, 16'h5555, 16'h1111, 11'h222, 8'h05, 8'h01, 16'h0000, 1'b1, 1'b1, 16'h5555, 1'b0, 16'h5556},
    {3'd3, 16'h8000, 16'h0000, 11'h000, 8'h00, 8'h02, 16'h7FFE, 1'b0, 1'b0, 16'h8000, 1'b1, 16'h8000},
    {3'd1, 16'h9999, 16'h0000, 11'h000, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000}
  };

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] k, input logic [15:0] np, input logic [15:0] la,
                       input logic [10:0] pa, input logic [7:0] ro, input logic [7:0] a,
                       input logic [15:0] dp, input logic up, input logic ct);
    @(negedge clk);
    in_valid = 1'b1; kind = k; next_pc = np; long_addr = la; page_addr = pa;
    rel_ofs = ro; acc = a; dptr = dp; idx_use_pc = up; cond_true = ct;
    @(negedge clk);
  endtask

  // Arithmetic model of the requirements
  function automatic logic [16:0] model_jump(input logic [2:0] k, input logic [15:0] np,
      input logic [15:0] la, input logic [10:0] pa, input logic [7:0] ro,
      input logic [7:0] a, input logic [15:0] dp, input logic ct);
    int rel;
    rel = (int'(np) + int'($signed(ro))) & 32'hFFFF;
    case (k)
      3'd1: return {1'b1, la};
      3'd2: return {1'b1, np[15:11], pa};
      3'd3: return {1'b1, rel[15:0]};
      3'd4: return ct ? {1'b1, rel[15:0]} : {1'b0, np};
      3'd5: return {1'b1, 16'((int'(dp) + int'(a)) & 32'hFFFF)};
      default: return {1'b0, np};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "out_valid", {15'd0, out_valid}, 16'd0);
    check("R1", "target", target, 16'h0000);
    check("R1", "taken", {15'd0, taken}, 16'd0);
    check("R1", "rd_addr", rd_addr, 16'h0000);
    rst = 1'b0;

    // Vector table: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][112:110], VEC[i][109:94], VEC[i][93:78], VEC[i][77:67],
            VEC[i][66:59], VEC[i][58:51], VEC[i][50:35], VEC[i][34], VEC[i][33]);
      check("R2", "out_valid", {15'd0, out_valid}, 16'd1);
      check("R3", $sformatf("vec%0d target", i), target, VEC[i][32:17]);
      check("R3", $sformatf("vec%0d taken", i), {15'd0, taken}, {15'd0, VEC[i][16]});
      check("R9", $sformatf("vec%0d rd_addr", i), rd_addr, VEC[i][15:0]);
    end

    // R2: idle cycle holds results even though inputs change
    @(negedge clk);
    in_valid = 1'b0; kind = 3'd1; long_addr = 16'h4444; acc = 8'h55;
    @(negedge clk);
    check("R2", "idle out_valid", {15'd0, out_valid}, 16'd0);
    check("R2", "idle target held", target, 16'h0000);
    check("R2", "idle taken held", {15'd0, taken}, 16'd1);
    check("R2", "idle rd_addr held", rd_addr, 16'h0000);

    // R8: idx_use_pc does not steer the indexed jump; R9 follows it
    drive(3'd5, 16'h3000, 16'h0000, 11'h000, 8'h10, 8'h10, 16'h2000, 1'b1, 1'b0);
    check("R8", "idx jump ignores pc select", target, 16'h2010);
    check("R9", "rd uses pc", rd_addr, 16'h3010);

    // R6: displacement -1 from page boundary 0x0800
    drive(3'd3, 16'h0800, 16'h0000, 11'h000, 8'hFF, 8'h00, 16'h0000, 1'b0, 1'b0);
    check("R6", "minus one", target, 16'h07FF);

    // R5: page splice at top page
    drive(3'd2, 16'hFFFF, 16'h0000, 11'h000, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0);
    check("R5", "top page base", target, 16'hF800);

    // R1: reset mid-run clears registered results
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R1", "mid reset valid", {15'd0, out_valid}, 16'd0);
    check("R1", "mid reset target", target, 16'h0000);
    check("R1", "mid reset taken", {15'd0, taken}, 16'd0);
    rst = 1'b0; in_valid = 1'b0;

    // Random sweep against the model: R3 R6 R7 R8 R9
    for (int n = 0; n < NRAND; n++) begin
      logic [2:0]  rk;
      logic [15:0] rnp, rla, rdp;
      logic [10:0] rpa;
      logic [7:0]  rro, ra;
      logic        rup, rct;
      logic [16:0] expj;
      logic [15:0] exprd;
      rk = 3'($urandom); rnp = 16'($urandom); rla = 16'($urandom);
      rdp = 16'($urandom); rpa = 11'($urandom); rro = 8'($urandom);
      ra = 8'($urandom); rup = 1'($urandom); rct = 1'($urandom);
      expj  = model_jump(rk, rnp, rla, rpa, rro, ra, rdp, rct);
      exprd = 16'(((rup ? int'(rnp) : int'(rdp)) + int'(ra)) & 32'hFFFF);
      drive(rk, rnp, rla, rpa, rro, ra, rdp, rup, rct);
      check("R3", $sformatf("rand%0d kind%0d target", n, rk), target, expj[15:0]);
      check("R7", $sformatf("rand%0d kind%0d taken", n, rk), {15'd0, taken}, {15'd0, expj[16]});
      check("R9", $sformatf("rand%0d rd_addr", n), rd_addr, exprd);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule